// File: doc/BRIEF.md
# Cursor Overlay Buffer Builder

This block assembles a hardware cursor image in a cursor buffer that the display path shows in place of the bitmap wherever the cursor sits. One start pulse runs one field's share of the work. For each cursor row, the block fetches a 16-bit cursor word from the cursor map and rotates it right by the cursor's bit offset within a word. It then reads the two bitmap words the cursor spans. It ORs the rotated pattern into the first word through the cursor mask and into the second word through the inverted mask, and it writes both merged words into the cursor buffer.

The display is interlaced, so each field handles only its own 8 rows. The map, bitmap and buffer pointers each step past the rows that belong to the other field. The buffer base for odd fields moves by half a row step. When the display is off or smooth scrolling is active, the block skips the copy and touches no memory. All memory traffic goes through one synchronous word port. A read returns its data exactly one cycle after the request.

Top module: `cursor_ovl_top`

## Requirements
- R1: After reset, mem_req_o, mem_we_o, busy_o and done_o are all low.
- R2: When start_i is accepted with display_on_i high and scroll_on_i low, busy_o rises on the next cycle and each of the 8 rows takes exactly five cycles in this order: cursor-map read, first bitmap read, first buffer write, second bitmap read, second buffer write. done_o is high for one cycle, 41 cycles after the edge that sampled start_i, and busy_o is low in that cycle.
- R3: Each run copies exactly 8 rows, which gives 16 cursor rows over two fields.
- R4: The bit offset is cursor_x_i[3:0] and the word column is cursor_x_i[9:4]. The first bitmap word of row 0 sits at cursor_line_i*64 + column, and the second bitmap word sits one address above it.
- R5: The cursor word for row 0 is read at map_base_i OR field parity (odd_field_i in bit 0). The block rotates that word right by the bit offset, so bit i moves to bit (i - offset) mod 16.
- R6: The first write stores bitmap word 0 OR (rotated AND mask). The second write stores bitmap word 1 OR (rotated AND NOT mask). Both use the mask captured at start.
- R7: The buffer address for row 0 is buf_base_i + column + 64 when odd_field_i is high, and buf_base_i + column when it is low. The second write goes one address above the first.
- R8: From one row to the next, the bitmap and buffer addresses each move up by 128 and the map address moves up by 2.
- R9: When the second write's address has 0xFF in its low 8 bits, that cycle carries no request, and the row still takes five cycles.
- R10: With display_on_i low or scroll_on_i high, start_i causes no memory request, busy_o stays low, and done_o is high in the cycle after the sampling edge.
- R11: A start_i pulse that arrives while busy_o is high has no effect on the writes or on the done timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to build this field's rows |
| cursor_x_i | input | 10 | Cursor X: column in [9:4], bit offset in [3:0] |
| cursor_line_i | input | 10 | Bitmap scan line of the first cursor row |
| cursor_mask_i | input | 16 | Selects the rotated bits that go into the first word |
| odd_field_i | input | 1 | Field parity, 1 for the odd field |
| display_on_i | input | 1 | Display enabled |
| scroll_on_i | input | 1 | Smooth scrolling active |
| map_base_i | input | 16 | Cursor map base address |
| buf_base_i | input | 16 | Cursor buffer base address |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | High for a write, low for a read |
| mem_addr_o | output | 16 | Word address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid one cycle after a read request |
| busy_o | output | 1 | A row copy is in progress |
| done_o | output | 1 | One-cycle completion flag |

## Verification
With start_i sampled at edge 0, row r (0-based) places its cursor-map read in the cycle after edge 5r. Its buffer writes come after edges 5r+2 and 5r+4, and done_o follows edge 40. A skipped run raises done_o right after edge 0. The bench drives inputs and samples on the falling edge, so it records every write in the cycle it appears and counts edges until done_o, comparing the count to 41 or to 1. Its memory model returns data computed from the address one edge after each read, which lets the bench predict every merged word from the address arithmetic alone.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RMAP,
    ST_RVIS0,
    ST_WR0,
    ST_RVIS1,
    ST_WR1,
    ST_DONE
  } ovl_state_e;
endpackage

// File: rtl/cursor_ovl_addr.sv
module cursor_ovl_addr #(
  parameter int DW         = 16,
  parameter int AW         = 16,
  parameter int LINE_WORDS = 64,
  parameter int XW         = $clog2(DW) + $clog2(LINE_WORDS),
  parameter int LW         = AW - $clog2(LINE_WORDS)
) (
  input  logic [XW-1:0]         cursor_x_i,
  input  logic [LW-1:0]         cursor_line_i,
  input  logic                  odd_field_i,
  input  logic [AW-1:0]         map_base_i,
  input  logic [AW-1:0]         buf_base_i,
  output logic [AW-1:0]         vis_start_o,
  output logic [AW-1:0]         buf_start_o,
  output logic [AW-1:0]         map_start_o,
  output logic [$clog2(DW)-1:0] ofs_o
);
  localparam int OFFW = $clog2(DW);
  localparam int COLW = $clog2(LINE_WORDS);

  logic [COLW-1:0] col;
  logic [AW-1:0]   odd_ofs;

  assign col         = cursor_x_i[XW-1:OFFW];
  assign ofs_o       = cursor_x_i[OFFW-1:0];
  assign odd_ofs     = odd_field_i ? AW'(LINE_WORDS) : '0;
  assign vis_start_o = {cursor_line_i, col};
  assign buf_start_o = buf_base_i + odd_ofs + AW'(col);
  assign map_start_o = map_base_i | AW'(odd_field_i);
endmodule

// File: rtl/cursor_ovl_merge.sv
module cursor_ovl_merge #(
  parameter int DW = 16
) (
  input  logic [DW-1:0]         word_i,
  input  logic [$clog2(DW)-1:0] ofs_i,
  input  logic [DW-1:0]         rot_q_i,
  input  logic [DW-1:0]         mask_i,
  input  logic                  second_i,
  output logic [DW-1:0]         rot_o,
  output logic [DW-1:0]         merged_o
);
  localparam int OFFW = $clog2(DW);

  logic [DW-1:0] stage [OFFW+1];
  assign stage[0] = word_i;

  // log-depth right rotator, one stage per offset bit
  for (genvar s = 0; s < OFFW; s++) begin : g_rot
    localparam int SH = 1 << s;
    assign stage[s+1] = ofs_i[s] ? {stage[s][SH-1:0], stage[s][DW-1:SH]} : stage[s];
  end

  assign rot_o = stage[OFFW];

  logic [DW-1:0] sel_mask;
  assign sel_mask = second_i ? ~mask_i : mask_i;
  assign merged_o = word_i | (rot_q_i & sel_mask);

  always_comb begin
    if ((merged_o & word_i) != word_i)
      assert_keep_bitmap_R6: assert (1'b0);
  end
endmodule

// File: rtl/cursor_ovl_seq.sv
module cursor_ovl_seq
  import cursor_ovl_pkg::*;
#(
  parameter int DW         = 16,
  parameter int AW         = 16,
  parameter int LINE_WORDS = 64,
  parameter int ROWS       = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  display_on_i,
  input  logic                  scroll_on_i,
  input  logic [AW-1:0]         vis_start_i,
  input  logic [AW-1:0]         buf_start_i,
  input  logic [AW-1:0]         map_start_i,
  input  logic [$clog2(DW)-1:0] ofs_i,
  input  logic [DW-1:0]         mask_i,
  input  logic [DW-1:0]         rot_i,
  input  logic [DW-1:0]         merged_i,
  output logic [$clog2(DW)-1:0] ofs_q_o,
  output logic [DW-1:0]         mask_q_o,
  output logic [DW-1:0]         rot_q_o,
  output logic                  second_o,
  output logic                  mem_req_o,
  output logic                  mem_we_o,
  output logic [AW-1:0]         mem_addr_o,
  output logic [DW-1:0]         mem_wdata_o,
  output logic                  busy_o,
  output logic                  done_o
);
  localparam int OFFW     = $clog2(DW);
  localparam int CNTW     = $clog2(ROWS + 1);
  localparam int ROW_STEP = 2 * LINE_WORDS;
  localparam int MAP_STEP = 2;

  ovl_state_e      state_q, state_d;
  logic [CNTW-1:0] cnt_q;
  logic [AW-1:0]   vis_q, buf_q, map_q;
  logic [OFFW-1:0] ofs_q;
  logic [DW-1:0]   mask_q, rot_q;
  logic            go, skip, suppress;
  logic [AW-1:0]   buf_hi;

  assign go       = (state_q == ST_IDLE) && start_i;
  assign skip     = !display_on_i || scroll_on_i;
  assign buf_hi   = buf_q + AW'(1);
  assign suppress = (buf_hi[7:0] == 8'hFF);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = skip ? ST_DONE : ST_RMAP;
      ST_RMAP:  state_d = ST_RVIS0;
      ST_RVIS0: state_d = ST_WR0;
      ST_WR0:   state_d = ST_RVIS1;
      ST_RVIS1: state_d = ST_WR1;
      ST_WR1:   state_d = (cnt_q == '0) ? ST_DONE : ST_RMAP;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      vis_q   <= '0;
      buf_q   <= '0;
      map_q   <= '0;
      ofs_q   <= '0;
      mask_q  <= '0;
      rot_q   <= '0;
    end else begin
      state_q <= state_d;
      if (go && !skip) begin
        cnt_q  <= CNTW'(ROWS - 1);
        vis_q  <= vis_start_i;
        buf_q  <= buf_start_i;
        map_q  <= map_start_i;
        ofs_q  <= ofs_i;
        mask_q <= mask_i;
      end
      if (state_q == ST_RVIS0) rot_q <= rot_i;
      if (state_q == ST_WR1) begin
        vis_q <= vis_q + AW'(ROW_STEP);
        buf_q <= buf_q + AW'(ROW_STEP);
        map_q <= map_q + AW'(MAP_STEP);
        if (cnt_q != '0) cnt_q <= cnt_q - CNTW'(1);
      end
    end
  end

  always_comb begin
    mem_req_o  = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = '0;
    unique case (state_q)
      ST_RMAP:  begin mem_req_o = 1'b1; mem_addr_o = map_q; end
      ST_RVIS0: begin mem_req_o = 1'b1; mem_addr_o = vis_q; end
      ST_WR0:   begin mem_req_o = 1'b1; mem_we_o = 1'b1; mem_addr_o = buf_q; end
      ST_RVIS1: begin mem_req_o = 1'b1; mem_addr_o = vis_q + AW'(1); end
      ST_WR1: begin
        mem_req_o  = !suppress;
        mem_we_o   = !suppress;
        mem_addr_o = buf_hi;
      end
      default: ;
    endcase
  end

  assign mem_wdata_o = merged_i;
  assign second_o    = (state_q == ST_WR1);
  assign ofs_q_o     = ofs_q;
  assign mask_q_o    = mask_q;
  assign rot_q_o     = rot_q;
  assign busy_o      = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done_o      = (state_q == ST_DONE);

  assert_row_limit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNTW'(ROWS - 1));
  assert_map_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WR1 && cnt_q != '0) |=> (map_q == $past(map_q) + AW'(MAP_STEP)) &&
                                            (vis_q == $past(vis_q) + AW'(ROW_STEP)));
  assert_no_ff_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (second_o && mem_addr_o[7:0] == 8'hFF) |-> !mem_req_o);
  assert_skip_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && skip) |=> done_o && !mem_req_o);
  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  assert_restart_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && state_q != ST_WR1) |=> busy_o);
endmodule

// File: rtl/cursor_ovl_top.sv
module cursor_ovl_top #(
  parameter int DW         = 16,
  parameter int AW         = 16,
  parameter int LINE_WORDS = 64,
  parameter int ROWS       = 8,
  parameter int XW         = $clog2(DW) + $clog2(LINE_WORDS),
  parameter int LW         = AW - $clog2(LINE_WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [XW-1:0] cursor_x_i,
  input  logic [LW-1:0] cursor_line_i,
  input  logic [DW-1:0] cursor_mask_i,
  input  logic          odd_field_i,
  input  logic          display_on_i,
  input  logic          scroll_on_i,
  input  logic [AW-1:0] map_base_i,
  input  logic [AW-1:0] buf_base_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o
);
  localparam int OFFW = $clog2(DW);

  logic [AW-1:0]   vis_start, buf_start, map_start;
  logic [OFFW-1:0] ofs, ofs_q;
  logic [DW-1:0]   mask_q, rot, rot_q, merged;
  logic            second;

  cursor_ovl_addr #(.DW(DW), .AW(AW), .LINE_WORDS(LINE_WORDS), .XW(XW), .LW(LW)) u_addr (
    .cursor_x_i    (cursor_x_i),
    .cursor_line_i (cursor_line_i),
    .odd_field_i   (odd_field_i),
    .map_base_i    (map_base_i),
    .buf_base_i    (buf_base_i),
    .vis_start_o   (vis_start),
    .buf_start_o   (buf_start),
    .map_start_o   (map_start),
    .ofs_o         (ofs)
  );

  cursor_ovl_merge #(.DW(DW)) u_merge (
    .word_i   (mem_rdata_i),
    .ofs_i    (ofs_q),
    .rot_q_i  (rot_q),
    .mask_i   (mask_q),
    .second_i (second),
    .rot_o    (rot),
    .merged_o (merged)
  );

  cursor_ovl_seq #(.DW(DW), .AW(AW), .LINE_WORDS(LINE_WORDS), .ROWS(ROWS)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .display_on_i (display_on_i),
    .scroll_on_i  (scroll_on_i),
    .vis_start_i  (vis_start),
    .buf_start_i  (buf_start),
    .map_start_i  (map_start),
    .ofs_i        (ofs),
    .mask_i       (cursor_mask_i),
    .rot_i        (rot),
    .merged_i     (merged),
    .ofs_q_o      (ofs_q),
    .mask_q_o     (mask_q),
    .rot_q_o      (rot_q),
    .second_o     (second),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  assert_write_is_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o && busy_o);
endmodule

// File: tb/cursor_ovl_top_tb_top.sv
`timescale 1ns/1ps
module cursor_ovl_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [9:0]  cursor_x_i = '0;
  logic [9:0]  cursor_line_i = '0;
  logic [15:0] cursor_mask_i = '0;
  logic        odd_field_i = 1'b0;
  logic        display_on_i = 1'b1;
  logic        scroll_on_i = 1'b0;
  logic [15:0] map_base_i = '0;
  logic [15:0] buf_base_i = '0;
  logic        mem_req_o, mem_we_o, busy_o, done_o;
  logic [15:0] mem_addr_o, mem_wdata_o;
  logic [15:0] mem_rdata_i = '0;

  int checks = 0;
  int errors = 0;
  int nw, nreq;
  logic [15:0] wa [32];
  logic [15:0] wd [32];

  always #10 clk_i = ~clk_i;

  cursor_ovl_top dut_i (.*);

  function automatic logic [15:0] memf(logic [15:0] a);
    return (a * 16'h9E37) ^ 16'h5A5A ^ (a >> 3);
  endfunction

  always @(posedge clk_i)
    if (mem_req_o && !mem_we_o) mem_rdata_i <= memf(mem_addr_o);

  always @(negedge clk_i) begin
    if (mem_req_o) nreq++;
    if (mem_req_o && mem_we_o && nw < 32) begin
      wa[nw] = mem_addr_o;
      wd[nw] = mem_wdata_o;
      nw++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [9:0] x, input logic [9:0] line, input logic [15:0] mask,
                     input logic odd, input logic don, input logic scr,
                     input logic [15:0] mbase, input logic [15:0] bbase, input bit restart);
    logic [15:0] ea [32];
    logic [15:0] ed [32];
    int ne = 0;
    int edges = 0;
    bit busy_seen = 0;
    logic [5:0] col = x[9:4];
    logic [3:0] off = x[3:0];
    logic [15:0] vis0 = {line, col};
    logic [15:0] b0 = bbase + (odd ? 16'd64 : 16'd0) + 16'(col);
    logic [15:0] m0 = mbase | 16'(odd);
    if (don && !scr) begin
      for (int r = 0; r < 8; r++) begin
        logic [31:0] t;
        logic [15:0] rot, v, b;
        t   = {memf(m0 + 16'(2*r)), memf(m0 + 16'(2*r))} >> off;
        rot = t[15:0];
        v   = vis0 + 16'(128*r);
        b   = b0 + 16'(128*r);
        ea[ne] = b; ed[ne] = memf(v) | (rot & mask); ne++;
        if (((b + 16'd1) & 16'hFF) != 16'hFF) begin
          ea[ne] = b + 16'd1; ed[ne] = memf(v + 16'd1) | (rot & ~mask); ne++;
        end
      end
    end
    @(negedge clk_i);
    cursor_x_i = x; cursor_line_i = line; cursor_mask_i = mask; odd_field_i = odd;
    display_on_i = don; scroll_on_i = scr; map_base_i = mbase; buf_base_i = bbase;
    start_i = 1'b1;
    nw = 0; nreq = 0;
    do begin
      @(posedge clk_i);
      edges++;
      @(negedge clk_i);
      start_i = (restart && edges == 7);
      if (busy_o) busy_seen = 1;
    end while (!done_o && edges < 300);
    start_i = 1'b0;
    if (don && !scr) begin
      chk(edges == 41, "R2 done timing", edges, 41);
      chk(busy_seen, "R2 busy", busy_seen, 1);
      chk(nw == ne, "R3 R9 write count", nw, ne);
      for (int i = 0; i < ne && i < nw; i++) begin
        chk(wa[i] == ea[i], "R4 R7 R8 write addr", wa[i], ea[i]);
        chk(wd[i] == ed[i], "R5 R6 write data", wd[i], ed[i]);
      end
      if (restart) chk(edges == 41 && nw == ne, "R11 restart ignored", edges, 41);
    end else begin
      chk(edges == 1, "R10 skip done", edges, 1);
      chk(nreq == 0 && !busy_seen, "R10 no access", nreq, 0);
    end
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R2 done one cycle", {done_o, busy_o}, 0);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!mem_req_o && !mem_we_o && !busy_o && !done_o, "R1 reset state",
        {mem_req_o, mem_we_o, busy_o, done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!mem_req_o && !busy_o && !done_o, "R1 idle after reset", {mem_req_o, busy_o, done_o}, 0);
    // sweep every bit offset against both field parities
    for (int o = 0; o < 16; o++)
      for (int p = 0; p < 2; p++)
        run({6'((o * 5 + p * 3) & 63), 4'(o)}, 10'(o * 7 + p), 16'hFFFF >> o,
            1'(p), 1'b1, 1'b0, 16'h2000 + 16'(o * 32), 16'h4000 + 16'(p * 256), 1'b0);
    // second write hits low byte FF on row 1 (R9)
    run({6'h3E, 4'd5}, 10'd100, 16'h07FF, 1'b1, 1'b1, 1'b0, 16'h3000, 16'h1000, 1'b0);
    run({6'h3F, 4'd9}, 10'd3, 16'h007F, 1'b0, 1'b1, 1'b0, 16'h3001, 16'h10C0, 1'b0);
    // skips (R10)
    run({6'h10, 4'd2}, 10'd50, 16'h3FFF, 1'b0, 1'b0, 1'b0, 16'h2000, 16'h4000, 1'b0);
    run({6'h10, 4'd2}, 10'd50, 16'h3FFF, 1'b1, 1'b1, 1'b1, 16'h2000, 16'h4000, 1'b0);
    // restart while busy (R11)
    run({6'h21, 4'd11}, 10'd200, 16'h001F, 1'b1, 1'b1, 1'b0, 16'h2200, 16'h5000, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule